// File: doc/BRIEF.md
# Paged MDIO to 32-bit Register Bridge

This block sits behind the slave end of a clause-22 management port and gives the host access to a 32-bit internal register space. The host sees only 16-bit registers. It first writes a page number to one reserved register. It then moves every 32-bit word as two 16-bit halves, and the PHY address and register number of each half-access supply the low address bits. On the far side the block acts as master of a simple internal register bus with a combinational read path.

A write of the low half only parks the data in a staging register. The internal write goes out when the matching high half arrives, carrying both halves at once, so an internal register never holds half-old, half-new contents. A read of the low half performs the full 32-bit internal read and keeps the upper half. The next high-half read returns that kept value, so both halves come from one instant. Request-side results appear combinationally in the cycle of the strobe. Write and read strobes are never raised together.

Top module: `mdio_page_bridge`

## Requirements
- R1: After reset the page register is 0, so a read of PHY 0x18 register 0 returns 0x0000, and no internal bus strobe is raised while no request is present.
- R2: A write to PHY 0x18 register 0 loads data bits [9:0] into the page. A read of the same address returns the page zero-extended to 16 bits. Data bits [15:10] are dropped.
- R3: An in-window access (PHY 0x10 to 0x17) drives the internal byte address as {page[9:0], PHY[2:0], register[4:1], 2'b00}, 19 bits wide. Page bits go on [18:9], the PHY bits on [8:6] and the register bits on [5:2].
- R4: An in-window write to an even register (register bit 0 = 0) raises no internal write and stores its data as the low half. An in-window write to an odd register raises the internal write enable in the same cycle, with write data {request data, stored low half}.
- R5: An in-window read of an even register raises the internal read enable in the same cycle and returns internal read data [15:0]. It also keeps internal read data [31:16].
- R6: An in-window read of an odd register raises no internal read. It returns the upper half kept by the latest even-register read, even if the internal data has changed since then.
- R7: A write to any PHY address below 0x10 or above 0x18, or to PHY 0x18 with a nonzero register, raises no internal write and leaves the page unchanged. A read of those addresses returns 0xFFFF and raises no internal read.
- R8: The page persists across any number of in-window accesses until the next page write. Every later internal address carries it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqPhy | input | 5 | PHY address of the request |
| reqReg | input | 5 | Register number of the request |
| reqWdata | input | 16 | Write data of the request |
| reqWr | input | 1 | Write strobe, one cycle per access |
| reqRd | input | 1 | Read strobe, one cycle per access |
| reqRdata | output | 16 | Read data, valid in the cycle of reqRd |
| busAddr | output | 19 | Internal byte address |
| busWdata | output | 32 | Internal write data |
| busWe | output | 1 | Internal write enable |
| busRe | output | 1 | Internal read enable |
| busRdata | input | 32 | Internal read data, combinational to busAddr |

## Verification
A wrong page shows up on the very next in-window access as bad upper address bits, and on a page read-back. A stale or corrupted staging register shows only when the next odd-register write goes out, as a wrong low half of the internal write data. A bad snapshot register stays hidden until the following high-half read. For that reason the internal read data is varied between the two half-reads, so a snapshot that is taken wrongly, or re-read live, returns a different value.

// File: rtl/mpb_pkg.sv
package mpb_pkg;
  typedef struct packed {
    logic loadPage;
    logic stageLow;
    logic latchHigh;
    logic selPage;
    logic selLow;
    logic selHigh;
  } ctrlStrb_t;
endpackage

// File: rtl/mpb_ctrl.sv
module mpb_ctrl
  import mpb_pkg::*;
#(
  parameter int unsigned PHY_W     = 5,
  parameter int unsigned REG_W     = 5,
  parameter int unsigned WIN_SEL_W = 3,
  parameter int unsigned PAGE_PHY  = 'h18
) (
  input  logic [PHY_W-1:0] reqPhy,
  input  logic [REG_W-1:0] reqReg,
  input  logic             reqWr,
  input  logic             reqRd,
  output ctrlStrb_t        strb,
  output logic             busWe,
  output logic             busRe
);
  localparam int unsigned TAG_W = PHY_W - WIN_SEL_W;
  localparam logic [TAG_W-1:0] WIN_TAG = TAG_W'(1) << (TAG_W - 1);

  logic winHit;
  logic pageHit;
  logic isHigh;

  assign winHit  = (reqPhy[PHY_W-1 -: TAG_W] == WIN_TAG);
  assign pageHit = (reqPhy == PHY_W'(PAGE_PHY)) && (reqReg == '0);
  assign isHigh  = reqReg[0];

  always_comb begin
    strb  = '0;
    busWe = 1'b0;
    busRe = 1'b0;
    if (reqWr) begin
      if (winHit && !isHigh) strb.stageLow = 1'b1;
      if (winHit && isHigh)  busWe = 1'b1;
      if (pageHit)           strb.loadPage = 1'b1;
    end else if (reqRd) begin
      if (winHit && !isHigh) begin
        busRe          = 1'b1;
        strb.latchHigh = 1'b1;
        strb.selLow    = 1'b1;
      end
      if (winHit && isHigh) strb.selHigh = 1'b1;
      if (pageHit)          strb.selPage = 1'b1;
    end
  end
endmodule

// File: rtl/mpb_dpath.sv
module mpb_dpath
  import mpb_pkg::*;
#(
  parameter int unsigned PAGE_W    = 10,
  parameter int unsigned PHY_W     = 5,
  parameter int unsigned REG_W     = 5,
  parameter int unsigned WIN_SEL_W = 3,
  parameter int unsigned HALF_W    = 16,
  localparam int unsigned LSB_W    = $clog2(2 * HALF_W / 8),
  localparam int unsigned ADDR_W   = PAGE_W + WIN_SEL_W + (REG_W - 1) + LSB_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrb_t           strb,
  input  logic [PHY_W-1:0]    reqPhy,
  input  logic [REG_W-1:0]    reqReg,
  input  logic [HALF_W-1:0]   reqWdata,
  input  logic [2*HALF_W-1:0] busRdata,
  output logic [ADDR_W-1:0]   busAddr,
  output logic [2*HALF_W-1:0] busWdata,
  output logic [HALF_W-1:0]   reqRdata
);
  logic [PAGE_W-1:0] pageQ;
  logic [HALF_W-1:0] stageQ;
  logic [HALF_W-1:0] snapQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageQ  <= '0;
      stageQ <= '0;
      snapQ  <= '0;
    end else begin
      if (strb.loadPage)  pageQ  <= reqWdata[PAGE_W-1:0];
      if (strb.stageLow)  stageQ <= reqWdata;
      if (strb.latchHigh) snapQ  <= busRdata[2*HALF_W-1:HALF_W];
    end
  end

  assign busAddr  = {pageQ, reqPhy[WIN_SEL_W-1:0], reqReg[REG_W-1:1], {LSB_W{1'b0}}};
  assign busWdata = {reqWdata, stageQ};

  always_comb begin
    reqRdata = '1;
    if (strb.selLow)  reqRdata = busRdata[HALF_W-1:0];
    if (strb.selHigh) reqRdata = snapQ;
    if (strb.selPage) reqRdata = HALF_W'(pageQ);
  end
endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
  import mpb_pkg::*;
#(
  parameter int unsigned PAGE_W    = 10,
  parameter int unsigned PHY_W     = 5,
  parameter int unsigned REG_W     = 5,
  parameter int unsigned WIN_SEL_W = 3,
  parameter int unsigned HALF_W    = 16,
  parameter int unsigned PAGE_PHY  = 'h18,
  localparam int unsigned LSB_W    = $clog2(2 * HALF_W / 8),
  localparam int unsigned ADDR_W   = PAGE_W + WIN_SEL_W + (REG_W - 1) + LSB_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PHY_W-1:0]    reqPhy,
  input  logic [REG_W-1:0]    reqReg,
  input  logic [HALF_W-1:0]   reqWdata,
  input  logic                reqWr,
  input  logic                reqRd,
  output logic [HALF_W-1:0]   reqRdata,
  output logic [ADDR_W-1:0]   busAddr,
  output logic [2*HALF_W-1:0] busWdata,
  output logic                busWe,
  output logic                busRe,
  input  logic [2*HALF_W-1:0] busRdata
);
  ctrlStrb_t strb;

  mpb_ctrl #(
    .PHY_W(PHY_W), .REG_W(REG_W), .WIN_SEL_W(WIN_SEL_W), .PAGE_PHY(PAGE_PHY)
  ) u_ctrl (
    .reqPhy(reqPhy), .reqReg(reqReg), .reqWr(reqWr), .reqRd(reqRd),
    .strb(strb), .busWe(busWe), .busRe(busRe)
  );

  mpb_dpath #(
    .PAGE_W(PAGE_W), .PHY_W(PHY_W), .REG_W(REG_W),
    .WIN_SEL_W(WIN_SEL_W), .HALF_W(HALF_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .reqPhy(reqPhy), .reqReg(reqReg),
    .reqWdata(reqWdata), .busRdata(busRdata), .busAddr(busAddr),
    .busWdata(busWdata), .reqRdata(reqRdata)
  );

  localparam int unsigned WIN_LO = 1 << (PHY_W - 1);
  localparam int unsigned WIN_HI = WIN_LO + (1 << WIN_SEL_W) - 1;

  logic inWin;
  logic outRange;
  logic pageWr;
  assign inWin    = (int'(reqPhy) >= WIN_LO) && (int'(reqPhy) <= WIN_HI);
  assign outRange = (int'(reqPhy) < WIN_LO) || (int'(reqPhy) > PAGE_PHY) ||
                    ((int'(reqPhy) == PAGE_PHY) && (reqReg != '0));
  assign pageWr   = reqWr && (int'(reqPhy) == PAGE_PHY) && (reqReg == '0);

  p_low_wr_staged_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqWr && inWin && !reqReg[0]) |-> !busWe);

  p_high_wr_pairs_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqWr && inWin && reqReg[0] && $past(reqWr && inWin && !reqReg[0]))
      |-> (busWe && busWdata[HALF_W-1:0] == $past(reqWdata)));

  p_high_rd_snapshot_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqRd && inWin && reqReg[0] && $past(busRe))
      |-> (!busRe && reqRdata == $past(busRdata[2*HALF_W-1:HALF_W])));

  p_out_of_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((reqWr || reqRd) && outRange)
      |-> (!busWe && !busRe && (!reqRd || reqRdata == '1)));

  p_page_to_addr_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((busWe || busRe) && $past(pageWr))
      |-> (busAddr[ADDR_W-1 -: PAGE_W] == $past(reqWdata[PAGE_W-1:0])));
endmodule

// File: tb/sim_mdio_page_bridge.sv
`timescale 1ns/1ps
module sim_mdio_page_bridge;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  reqPhy = '0;
  logic [4:0]  reqReg = '0;
  logic [15:0] reqWdata = '0;
  logic        reqWr = 1'b0;
  logic        reqRd = 1'b0;
  logic [15:0] reqRdata;
  logic [18:0] busAddr;
  logic [31:0] busWdata;
  logic        busWe;
  logic        busRe;
  logic [31:0] busRdata;
  logic [15:0] salt = 16'h5a5a;

  always #5 clk = ~clk;

  assign busRdata = {busAddr[15:0] ^ salt, ~busAddr[15:0]};

  mdio_page_bridge u0 (
    .clk(clk), .rstN(rstN), .reqPhy(reqPhy), .reqReg(reqReg),
    .reqWdata(reqWdata), .reqWr(reqWr), .reqRd(reqRd), .reqRdata(reqRdata),
    .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe), .busRe(busRe),
    .busRdata(busRdata)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  logic [9:0]  bPage = '0;
  logic [15:0] bStage = '0;
  logic [15:0] bSnap = '0;
  logic [15:0] obsRd;
  logic [18:0] obsAddr;
  logic [31:0] obsWdata;
  logic        obsWe, obsRe;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [18:0] expAddr(input logic [4:0] phy, input logic [4:0] rg);
    return {bPage, phy[2:0], rg[4:1], 2'b00};
  endfunction

  task automatic access(input bit wr, input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    @(negedge clk);
    reqPhy = phy; reqReg = rg; reqWdata = d; reqWr = wr; reqRd = !wr;
    #2;
    obsRd = reqRdata; obsAddr = busAddr; obsWdata = busWdata;
    obsWe = busWe; obsRe = busRe;
    @(posedge clk);
    #1;
    reqWr = 1'b0; reqRd = 1'b0;
  endtask

  task automatic runOp(input bit wr, input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    bit inWin, pg;
    logic [18:0] ea;
    inWin = (phy >= 5'h10) && (phy <= 5'h17);
    pg    = (phy == 5'h18) && (rg == 5'd0);
    ea    = expAddr(phy, rg);
    access(wr, phy, rg, d);
    if (wr) begin
      if (inWin && !rg[0]) begin
        chk(!obsWe, "R4 low write no bus write", 32'(obsWe), 0);
        bStage = d;
      end else if (inWin) begin
        chk(obsWe, "R4 high write strobe", 32'(obsWe), 1);
        chk(obsAddr == ea, "R3 write address", 32'(obsAddr), 32'(ea));
        chk(obsWdata == {d, bStage}, "R4 write data", obsWdata, {d, bStage});
      end else if (pg) begin
        chk(!obsWe, "R2 page write no bus write", 32'(obsWe), 0);
        bPage = d[9:0];
      end else begin
        chk(!obsWe, "R7 ignored write", 32'(obsWe), 0);
      end
    end else begin
      if (inWin && !rg[0]) begin
        chk(obsRe, "R5 low read strobe", 32'(obsRe), 1);
        chk(obsAddr == ea, "R3 read address", 32'(obsAddr), 32'(ea));
        chk(obsRd == ~ea[15:0], "R5 low read data", 32'(obsRd), 32'(~ea[15:0]));
        bSnap = ea[15:0] ^ salt;
      end else if (inWin) begin
        chk(!obsRe, "R6 high read no bus read", 32'(obsRe), 0);
        chk(obsRd == bSnap, "R6 high read snapshot", 32'(obsRd), 32'(bSnap));
      end else if (pg) begin
        chk(obsRd == {6'b0, bPage}, "R2 page readback", 32'(obsRd), 32'({6'b0, bPage}));
      end else begin
        chk(!obsRe, "R7 ignored read no bus read", 32'(obsRe), 0);
        chk(obsRd == 16'hffff, "R7 ignored read data", 32'(obsRd), 32'hffff);
      end
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [4:0] phy;
    void'($urandom(32'h1d2c3b4a));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1: idle strobes and reset page
    @(negedge clk);
    chk(!busWe && !busRe, "R1 idle strobes", {busWe, busRe}, 0);
    runOp(0, 5'h18, 5'd0, 16'h0);
    chk(obsRd == 16'h0000, "R1 reset page", 32'(obsRd), 0);
    // R2: page load with upper bits dropped
    runOp(1, 5'h18, 5'd0, 16'hfea5);
    runOp(0, 5'h18, 5'd0, 16'h0);
    // R7: ignored writes leave the page alone
    runOp(1, 5'h18, 5'd2, 16'h0011);
    runOp(1, 5'h05, 5'd0, 16'h1234);
    runOp(1, 5'h1f, 5'd1, 16'h4321);
    runOp(0, 5'h18, 5'd0, 16'h0);
    runOp(0, 5'h19, 5'd0, 16'h0);
    runOp(0, 5'h0f, 5'd4, 16'h0);
    // R4: low then high write at the window edges
    runOp(1, 5'h17, 5'd30, 16'hbeef);
    runOp(1, 5'h17, 5'd31, 16'hdead);
    runOp(1, 5'h10, 5'd0, 16'h0102);
    runOp(1, 5'h10, 5'd1, 16'h0304);
    // R5 / R6: snapshot survives a change of internal data
    runOp(0, 5'h12, 5'd6, 16'h0);
    salt = 16'h1357;
    runOp(0, 5'h12, 5'd7, 16'h0);
    // R8: page change carries into later addresses
    runOp(1, 5'h18, 5'd0, 16'h0201);
    runOp(0, 5'h13, 5'd8, 16'h0);
    runOp(1, 5'h13, 5'd9, 16'h7777);
    // random mix
    for (int i = 0; i < 400; i++) begin
      int sel;
      sel = int'($urandom_range(0, 99));
      if (sel < 70)      phy = 5'h10 | 5'($urandom_range(0, 7));
      else if (sel < 85) phy = 5'h18;
      else               phy = 5'($urandom_range(0, 31));
      salt = 16'($urandom());
      runOp(bit'($urandom_range(0, 1)), phy,
            (phy == 5'h18 && sel < 82) ? 5'd0 : 5'($urandom_range(0, 31)),
            16'($urandom()));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule